// File: doc/BRIEF.md
# Real-Time Counter with Locked Configuration

This block keeps time from a slow counting enable. A 20-bit prescaler counts down from a reload value once per enable pulse. When it passes zero it emits a tick and reloads. Each tick advances a 32-bit time counter, which is compared against a 32-bit alarm value. Three events are recorded in sticky flags: the periodic tick, an alarm match, and a counter wrap. Each flag drives its own interrupt output through an enable bit.

Software can change the reload, counter and alarm values only after setting a configuration bit in the control register. While that bit is set, writes land in shadow copies and the live values keep running untouched. Clearing the bit starts a commit that lasts three enable pulses. During the commit the write-done status reads 0. The shadow values then replace the live ones together. A resync flag, cleared by software, is set again by the next enable pulse. This tells software that what it reads reflects the slow time base.

Top module: `rtc_timer`

## Requirements
- R1: With reload value N, a tick happens on every (N+1)th countEn pulse, and each tick adds 1 to the counter. Without countEn pulses the counter never changes.
- R2: Every tick sets the second flag (flags register bit 0).
- R3: A tick that moves the counter onto the live alarm value sets the alarm flag (flags bit 1).
- R4: A tick taken while the counter is 0xFFFFFFFF makes the counter 0 and sets the overflow flag (flags bit 2).
- R5: A write to reload (address 2), counter (address 3) or alarm (address 4) has no effect unless control bit 0 (configuration) is set and no commit is in progress.
- R6: Accepted writes are staged. Reads of addresses 2–4 keep returning the live values until the commit.
- R7: Writing 0 to control bit 0 while it is 1 drives control bit 4 (write-done) low. On the third countEn pulse that follows, the staged values become live and write-done returns to 1.
- R8: Outputs irqSec, irqAlarm and irqWrap are each the AND of their flag and an enable bit. The enables are control bits 1, 2 and 3, in that order.
- R9: A flag clears only when 0 is written to its bit at address 1. Writing 1 has no effect, and a flag set by hardware in the same cycle stays set.
- R10: The resync flag (flags bit 3) is 0 after reset and is cleared by writing 0 to that bit. It is set by the next countEn pulse.
- R11: If a counter commit falls on the same pulse as a tick, the counter takes the committed value with no increment. The tick still sets the second flag.
- R12: After reset the control register reads 0x10, the flags read 0, and the counter and alarm read 0. The reload reads its reset parameter, which defaults to 32767.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| countEn | input | 1 | One-cycle pulse standing in for a slow clock edge |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Write address (0 ctrl, 1 flags, 2 reload, 3 counter, 4 alarm) |
| wrData | input | 32 | Write data |
| rdAddr | input | 3 | Read address, same map |
| rdData | output | 32 | Read data (combinational) |
| irqSec | output | 1 | Tick interrupt |
| irqAlarm | output | 1 | Alarm interrupt |
| irqWrap | output | 1 | Overflow interrupt |

## Verification
The counter is driven with a small reload, so single ticks can be isolated. Counting with no enable pulses shows that the counter advances only on the slow time base. Commits are issued with the prescaler at several phases. When the divider is mid-count, the commit is plainly visible. When the commit lands on a tick, the rule that the commit wins can be told apart from an extra increment. Loading a value just below the wrap point, and an alarm just ahead of the count, separates the overflow event from the match event. Writes sent outside configuration mode are then followed by a real commit, which shows whether they leaked into the staged values.

// File: rtl/rtc_timer_pkg.sv
package rtc_timer_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_FLAGS  = 3'd1;
  localparam logic [ADDR_W-1:0] A_RELOAD = 3'd2;
  localparam logic [ADDR_W-1:0] A_COUNT  = 3'd3;
  localparam logic [ADDR_W-1:0] A_ALARM  = 3'd4;

  typedef struct packed {
    logic wrReload;
    logic wrCount;
    logic wrAlarm;
    logic commit;
    logic ldReload;
    logic ldCount;
    logic ldAlarm;
  } dpStrobes_t;

  typedef struct packed {
    logic wrapHit;
    logic alarmHit;
    logic tick;
  } dpEvents_t;
endpackage

// File: rtl/rtc_timer_ctrl.sv
module rtc_timer_ctrl
  import rtc_timer_pkg::*;
#(
  parameter int COMMIT_LEN = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              countEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [3:0]        wrBits,
  input  dpEvents_t         evt,
  output dpStrobes_t        strb,
  output logic              cfgMode,
  output logic [2:0]        ieVec,
  output logic [2:0]        flagVec,
  output logic              syncFlag,
  output logic              writeDone
);
  localparam int BW = $clog2(COMMIT_LEN + 1);

  logic [BW-1:0] busyCnt;
  logic [2:0]    pending;  // {reload, count, alarm}
  logic          ctrlWr, flagWr, shadowOk, commitNow, startCommit;
  logic [2:0]    evtVec;

  assign ctrlWr      = wrEn && (wrAddr == A_CTRL);
  assign flagWr      = wrEn && (wrAddr == A_FLAGS);
  assign writeDone   = (busyCnt == '0);
  assign shadowOk    = cfgMode && writeDone;
  assign commitNow   = (busyCnt == BW'(1)) && countEn;
  assign startCommit = ctrlWr && cfgMode && !wrBits[0] && writeDone;
  assign evtVec      = {evt.wrapHit, evt.alarmHit, evt.tick};

  always_comb begin
    strb          = '0;
    strb.wrReload = wrEn && (wrAddr == A_RELOAD) && shadowOk;
    strb.wrCount  = wrEn && (wrAddr == A_COUNT)  && shadowOk;
    strb.wrAlarm  = wrEn && (wrAddr == A_ALARM)  && shadowOk;
    strb.commit   = commitNow;
    strb.ldReload = commitNow && pending[2];
    strb.ldCount  = commitNow && pending[1];
    strb.ldAlarm  = commitNow && pending[0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgMode  <= 1'b0;
      ieVec    <= '0;
      busyCnt  <= '0;
      pending  <= '0;
      syncFlag <= 1'b0;
    end else begin
      if (ctrlWr) begin
        cfgMode <= wrBits[0];
        ieVec   <= wrBits[3:1];
      end
      if (startCommit)               busyCnt <= BW'(COMMIT_LEN);
      else if (!writeDone && countEn) busyCnt <= busyCnt - BW'(1);
      if (commitNow) pending <= '0;
      else pending <= pending | {strb.wrReload, strb.wrCount, strb.wrAlarm};
      if (countEn)                     syncFlag <= 1'b1;
      else if (flagWr && !wrBits[3])   syncFlag <= 1'b0;
    end
  end

  for (genvar i = 0; i < 3; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rstN) flagVec[i] <= 1'b0;
      else flagVec[i] <= ((flagWr ? wrBits[i] : 1'b1) & flagVec[i]) | evtVec[i];
    end
  end

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    flagVec[0] && !(flagWr && !wrBits[0]) |=> flagVec[0]); // R9
  AST_DONE_ON_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(writeDone) |-> $past(countEn)); // R7
endmodule

// File: rtl/rtc_timer_dp.sv
module rtc_timer_dp
  import rtc_timer_pkg::*;
#(
  parameter int CNT_W      = 32,
  parameter int DIV_W      = 20,
  parameter int RELOAD_RST = 32767
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             countEn,
  input  logic [CNT_W-1:0] wrData,
  input  dpStrobes_t       strb,
  output dpEvents_t        evt,
  output logic [CNT_W-1:0] liveCount,
  output logic [CNT_W-1:0] liveAlarm,
  output logic [DIV_W-1:0] liveReload
);
  logic [DIV_W-1:0] divCnt, shReload;
  logic [CNT_W-1:0] shCount, shAlarm, countInc;
  logic             tick;

  assign tick         = countEn && (divCnt == '0);
  assign countInc     = liveCount + CNT_W'(1);
  assign evt.tick     = tick;
  assign evt.alarmHit = tick && !strb.ldCount && (countInc == liveAlarm);
  assign evt.wrapHit  = tick && !strb.ldCount && (&liveCount);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReload   <= DIV_W'(RELOAD_RST);
      shCount    <= '0;
      shAlarm    <= '0;
      liveReload <= DIV_W'(RELOAD_RST);
      divCnt     <= DIV_W'(RELOAD_RST);
      liveCount  <= '0;
      liveAlarm  <= '0;
    end else begin
      if (strb.wrReload) shReload <= wrData[DIV_W-1:0];
      if (strb.wrCount)  shCount  <= wrData;
      if (strb.wrAlarm)  shAlarm  <= wrData;
      if (strb.ldReload) liveReload <= shReload;
      if (strb.ldAlarm)  liveAlarm  <= shAlarm;
      if (strb.ldReload)   divCnt <= shReload;
      else if (tick)       divCnt <= liveReload;
      else if (countEn)    divCnt <= divCnt - DIV_W'(1);
      if (strb.ldCount)  liveCount <= shCount;
      else if (tick)     liveCount <= countInc;
    end
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !countEn |=> $stable(liveCount)); // R1
  AST_STAGED_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !countEn |=> $stable(liveAlarm) && $stable(liveReload)); // R6
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    evt.wrapHit |=> (liveCount == '0)); // R4
  AST_COMMIT_WINS: assert property (@(posedge clk) disable iff (!rstN)
    strb.ldCount |=> (liveCount == $past(shCount))); // R11
endmodule

// File: rtl/rtc_timer.sv
module rtc_timer
  import rtc_timer_pkg::*;
#(
  parameter int CNT_W      = 32,
  parameter int DIV_W      = 20,
  parameter int RELOAD_RST = 32767,
  parameter int COMMIT_LEN = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              countEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [CNT_W-1:0]  rdData,
  output logic              irqSec,
  output logic              irqAlarm,
  output logic              irqWrap
);
  dpStrobes_t       strb;
  dpEvents_t        evt;
  logic             cfgMode, syncFlag, writeDone;
  logic [2:0]       ieVec, flagVec;
  logic [CNT_W-1:0] liveCount, liveAlarm;
  logic [DIV_W-1:0] liveReload;

  rtc_timer_ctrl #(.COMMIT_LEN(COMMIT_LEN)) ctrl_i (
    .clk(clk), .rstN(rstN), .countEn(countEn), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrBits(wrData[3:0]), .evt(evt), .strb(strb), .cfgMode(cfgMode),
    .ieVec(ieVec), .flagVec(flagVec), .syncFlag(syncFlag), .writeDone(writeDone)
  );

  rtc_timer_dp #(.CNT_W(CNT_W), .DIV_W(DIV_W), .RELOAD_RST(RELOAD_RST)) dp_i (
    .clk(clk), .rstN(rstN), .countEn(countEn), .wrData(wrData), .strb(strb),
    .evt(evt), .liveCount(liveCount), .liveAlarm(liveAlarm), .liveReload(liveReload)
  );

  assign irqSec   = flagVec[0] & ieVec[0];
  assign irqAlarm = flagVec[1] & ieVec[1];
  assign irqWrap  = flagVec[2] & ieVec[2];

  always_comb begin
    unique case (rdAddr)
      A_CTRL:   rdData = CNT_W'({writeDone, ieVec, cfgMode});
      A_FLAGS:  rdData = CNT_W'({syncFlag, flagVec});
      A_RELOAD: rdData = CNT_W'(liveReload);
      A_COUNT:  rdData = liveCount;
      A_ALARM:  rdData = liveAlarm;
      default:  rdData = '0;
    endcase
  end
endmodule

// File: tb/rtc_timer_tb_top.sv
module rtc_timer_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        countEn = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [2:0]  rdAddr = '0;
  logic [31:0] rdData;
  logic        irqSec, irqAlarm, irqWrap;
  int          nChk = 0;
  int          nBad = 0;
  bit          finished = 1'b0;

  always #10 clk = ~clk;

  rtc_timer dut_i (
    .clk(clk), .rstN(rstN), .countEn(countEn), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData), .irqSec(irqSec),
    .irqAlarm(irqAlarm), .irqWrap(irqWrap)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); rdAddr = a; #1 d = rdData;
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); countEn = 1'b1;
      @(negedge clk); countEn = 1'b0;
    end
  endtask

  task automatic test_reset();
    logic [31:0] v;
    rd(3'd0, v); chk("R12 ctrl", v, 32'h10);
    rd(3'd1, v); chk("R12 flags", v, 32'h0);
    rd(3'd2, v); chk("R12 reload", v, 32'd32767);
    rd(3'd3, v); chk("R12 count", v, 32'h0);
    rd(3'd4, v); chk("R12 alarm", v, 32'h0);
    pulse(1);
    rd(3'd1, v); chk("R10 resync set", v, 32'h8);
  endtask

  task automatic test_commit();
    logic [31:0] v;
    wr(3'd0, 32'h1);
    wr(3'd2, 32'd3); wr(3'd3, 32'd10); wr(3'd4, 32'd12);
    rd(3'd3, v); chk("R6 count staged", v, 32'h0);
    rd(3'd2, v); chk("R6 reload staged", v, 32'd32767);
    wr(3'd0, 32'h0);
    rd(3'd0, v); chk("R7 busy", v, 32'h0);
    pulse(2);
    rd(3'd0, v); chk("R7 still busy", v, 32'h0);
    rd(3'd3, v); chk("R7 not yet live", v, 32'h0);
    pulse(1);
    rd(3'd0, v); chk("R7 done", v, 32'h10);
    rd(3'd3, v); chk("R7 count live", v, 32'd10);
    rd(3'd2, v); chk("R7 reload live", v, 32'd3);
  endtask

  task automatic test_tick_alarm();
    logic [31:0] v;
    pulse(3);
    rd(3'd3, v); chk("R1 no early tick", v, 32'd10);
    pulse(1);
    rd(3'd3, v); chk("R1 tick", v, 32'd11);
    rd(3'd1, v); chk("R2 second flag", v, 32'h9);
    repeat (20) @(negedge clk);
    rd(3'd3, v); chk("R1 idle hold", v, 32'd11);
    pulse(3);
    rd(3'd1, v); chk("R3 no early alarm", v & 32'h2, 32'h0);
    pulse(1);
    rd(3'd3, v); chk("R3 count", v, 32'd12);
    rd(3'd1, v); chk("R3 alarm flag", v, 32'hB);
  endtask

  task automatic test_lock();
    logic [31:0] v;
    wr(3'd3, 32'd99);
    rd(3'd3, v); chk("R5 ignored", v, 32'd12);
    wr(3'd0, 32'h1); wr(3'd4, 32'd500); wr(3'd0, 32'h0);
    pulse(3);
    rd(3'd3, v); chk("R5 not staged", v, 32'd12);
    rd(3'd4, v); chk("R5 alarm committed", v, 32'd500);
  endtask

  task automatic test_flags_irq();
    logic [31:0] v;
    wr(3'd1, 32'hE);
    rd(3'd1, v); chk("R9 clear sec only", v, 32'hA);
    wr(3'd0, 32'h2);
    chk("R8 sec irq off", {31'b0, irqSec}, 32'h0);
    chk("R8 alarm irq masked", {31'b0, irqAlarm}, 32'h0);
    wr(3'd0, 32'h6);
    chk("R8 alarm irq on", {31'b0, irqAlarm}, 32'h1);
    pulse(1);
    rd(3'd3, v); chk("R1 tick after lock", v, 32'd13);
    chk("R8 sec irq", {31'b0, irqSec}, 32'h1);
  endtask

  task automatic test_wrap();
    logic [31:0] v;
    wr(3'd0, 32'h7); wr(3'd3, 32'hFFFF_FFFE); wr(3'd0, 32'h6);
    pulse(3);
    rd(3'd3, v); chk("R7 near wrap", v, 32'hFFFF_FFFE);
    pulse(1);
    rd(3'd3, v); chk("R4 max", v, 32'hFFFF_FFFF);
    rd(3'd1, v); chk("R4 no early wrap", v & 32'h4, 32'h0);
    pulse(4);
    rd(3'd3, v); chk("R4 wrapped", v, 32'h0);
    rd(3'd1, v); chk("R4 wrap flag", v & 32'h4, 32'h4);
    chk("R8 wrap irq masked", {31'b0, irqWrap}, 32'h0);
  endtask

  task automatic test_coincide();
    logic [31:0] v;
    wr(3'd0, 32'h7);
    pulse(1);
    wr(3'd3, 32'd1000); wr(3'd0, 32'h6);
    pulse(3);
    rd(3'd3, v); chk("R11 commit wins", v, 32'd1000);
    rd(3'd0, v); chk("R11 done", v, 32'h16);
    pulse(3);
    rd(3'd3, v); chk("R11 hold", v, 32'd1000);
    pulse(1);
    rd(3'd3, v); chk("R11 next tick", v, 32'd1001);
  endtask

  task automatic test_resync();
    logic [31:0] v;
    wr(3'd1, 32'h7);
    rd(3'd1, v); chk("R10 cleared", v, 32'h7);
    pulse(1);
    rd(3'd1, v); chk("R10 reset again", v, 32'hF);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    test_reset();
    test_commit();
    test_tick_alarm();
    test_lock();
    test_flags_irq();
    test_wrap();
    test_coincide();
    test_resync();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChk++; nBad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end
endmodule